// File: doc/BRIEF.md
# Pipelined Multiply-Add Datapath

This block computes `A*B + C` on a stream of unsigned operand sets and accepts a new set on every clock. It is built from three register segments. The first segment captures the two factors. The second segment forms their product and, on the same edge, captures the addend. The third segment adds the two and registers the sum. A one-bit valid flag travels beside the data through each segment, so an idle input cycle leaves the pipe as an idle output cycle and does not disturb sets already in flight.

The addend does not arrive with the factors. The caller presents `A` and `B` with `in_vld` high, and then presents the matching `C` on the following clock, because `C` is sampled by segment two. Once the pipe is full it delivers one finished sum per clock, and `n` sets pass through the three segments in `3 + (n - 1)` clocks. The product can come from the plain operator or from an unrolled shift-and-add array. A parameter picks the variant at elaboration.

Top module: `madd_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears the valid flag of every segment. `out_vld` is low in the cycle after any clock edge at which `rst` was high, and any set in flight at that edge is dropped.
- R2: When `out_vld` is high, `out_res` equals `A*B + C` as unsigned integers. Here `A` and `B` were on `in_a`/`in_b` with `in_vld` high at some clock edge, and `C` was on `in_c` at the next clock edge.
- R3: A set captured at clock edge `e` raises `out_vld` with its result after edge `e+2`, three edges counting the capture edge. It stays high for exactly one cycle.
- R4: Sets offered on consecutive clocks leave on consecutive clocks with no gap. A run of `n` back-to-back sets takes `3 + (n - 1)` clock edges from the first capture to the last result.
- R5: A cycle with `in_vld` low yields a cycle with `out_vld` low three edges later. A gap of `m` input cycles gives a gap of exactly `m` output cycles, and the sets on both sides of the gap keep their correct results.
- R6: `out_res` is `2W+1` bits wide, so the largest operands (`A = B = 2^W-1`, `C = 2^(2W)-1`) give their exact sum without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_vld | input | 1 | High when `in_a`/`in_b` carry a new operand set |
| in_a | input | W | First factor, unsigned |
| in_b | input | W | Second factor, unsigned |
| in_c | input | 2W | Addend, unsigned; sampled one clock after its factors |
| out_vld | output | 1 | High when `out_res` holds a finished sum |
| out_res | output | 2W+1 | Result `A*B + C` |

## Verification
Capturing a new set in segment one and capturing an addend in segment two can fall on the same edge. The same holds for a reset and a set that is in flight. The bench provokes the first by streaming back-to-back sets and random bursts. The `in_c` of each cycle belongs to the set from the previous cycle while `in_a`/`in_b` already carry the next set, and every result is compared with a sum built from the bench's own per-cycle history. The bench provokes the second by pulsing `rst` while the pipe is full. It then judges that no set caught in the pipe ever appears at the output, and that sets offered after the reset come out correctly.

// File: rtl/madd_pkg.sv
package madd_pkg;

   // Product width for a W-bit by W-bit unsigned multiply
   function automatic int prod_width(input int w);
      return 2 * w;
   endfunction

   // Sum width: one carry bit above the product
   function automatic int sum_width(input int w);
      return 2 * w + 1;
   endfunction

   // Multiplier variant selectors
   localparam int MUL_OPERATOR  = 0;
   localparam int MUL_SHIFT_ADD = 1;

endpackage

// File: rtl/madd_seg_in.sv
module madd_seg_in #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         vld_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         vld_o,
   output logic [W-1:0] a_o,
   output logic [W-1:0] b_o
);

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   // Factor registers load only for a real set; bubbles leave them alone
   always_ff @(posedge clk) begin
      if (vld_i) begin
         a_o <= a_i;
         b_o <= b_i;
      end
   end

   // R5
   seg_in_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/madd_seg_mul.sv
module madd_seg_mul
   import madd_pkg::*;
#(
   parameter int W         = 8,
   parameter int MUL_STYLE = MUL_OPERATOR
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [W-1:0]             a_i,
   input  logic [W-1:0]             b_i,
   input  logic [prod_width(W)-1:0] c_i,
   output logic                     vld_o,
   output logic [prod_width(W)-1:0] p_o,
   output logic [prod_width(W)-1:0] c_o
);

   localparam int PW = prod_width(W);

   logic [PW-1:0] prod;

   generate
      if (MUL_STYLE == MUL_SHIFT_ADD) begin : g_shift_add
         logic [PW-1:0] part [W+1];
         logic [PW-1:0] a_ext;
         assign a_ext   = {{W{1'b0}}, a_i};
         assign part[0] = '0;
         for (genvar i = 0; i < W; i++) begin : g_row
            assign part[i+1] = part[i] + (b_i[i] ? (a_ext << i) : '0);
         end
         assign prod = part[W];
      end else begin : g_operator
         assign prod = PW'(a_i) * PW'(b_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   // Addend sampled only alongside a valid product
   always_ff @(posedge clk) begin
      if (vld_i) begin
         p_o <= prod;
         c_o <= c_i;
      end
   end

   // R2
   seg_mul_product_chk: assert property (@(posedge clk) disable iff (rst)
      vld_o |-> (p_o == PW'($past(a_i)) * PW'($past(b_i))));

   // R5
   seg_mul_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/madd_seg_add.sv
module madd_seg_add
   import madd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [prod_width(W)-1:0] p_i,
   input  logic [prod_width(W)-1:0] c_i,
   output logic                     vld_o,
   output logic [sum_width(W)-1:0]  s_o
);

   localparam int SW = sum_width(W);

   logic [SW-1:0] sum;
   assign sum = SW'(p_i) + SW'(c_i);

   always_ff @(posedge clk) begin
      if (rst) vld_o <= 1'b0;
      else     vld_o <= vld_i;
   end

   always_ff @(posedge clk) begin
      if (vld_i) s_o <= sum;
   end

   // R5
   seg_add_vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (vld_o == $past(vld_i)));

endmodule

// File: rtl/madd_pipe.sv
module madd_pipe
   import madd_pkg::*;
#(
   parameter int W         = 8,
   parameter int MUL_STYLE = MUL_OPERATOR
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_vld,
   input  logic [W-1:0]             in_a,
   input  logic [W-1:0]             in_b,
   input  logic [2*W-1:0]           in_c,
   output logic                     out_vld,
   output logic [2*W:0]             out_res
);

   localparam int PW = prod_width(W);
   localparam int SW = sum_width(W);

   typedef logic [SW-1:0] sum_t;

   generate
      if (W < 2 || W > 32) begin : g_bad_width
         $error("madd_pipe: W must lie in 2..32");
      end
      if (MUL_STYLE != MUL_OPERATOR && MUL_STYLE != MUL_SHIFT_ADD) begin : g_bad_style
         $error("madd_pipe: unknown MUL_STYLE");
      end
   endgenerate

   logic          s1_vld;
   logic [W-1:0]  s1_a;
   logic [W-1:0]  s1_b;
   logic          s2_vld;
   logic [PW-1:0] s2_p;
   logic [PW-1:0] s2_c;

   madd_seg_in #(.W(W)) u_seg_in (
      .clk   (clk),
      .rst   (rst),
      .vld_i (in_vld),
      .a_i   (in_a),
      .b_i   (in_b),
      .vld_o (s1_vld),
      .a_o   (s1_a),
      .b_o   (s1_b)
   );

   madd_seg_mul #(.W(W), .MUL_STYLE(MUL_STYLE)) u_seg_mul (
      .clk   (clk),
      .rst   (rst),
      .vld_i (s1_vld),
      .a_i   (s1_a),
      .b_i   (s1_b),
      .c_i   (in_c),
      .vld_o (s2_vld),
      .p_o   (s2_p),
      .c_o   (s2_c)
   );

   madd_seg_add #(.W(W)) u_seg_add (
      .clk   (clk),
      .rst   (rst),
      .vld_i (s2_vld),
      .p_i   (s2_p),
      .c_i   (s2_c),
      .vld_o (out_vld),
      .s_o   (out_res)
   );

   // R1
   rst_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_vld);

   // R3
   latency_three_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> $past(in_vld, 3));

   // R2
   result_value_chk: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> (out_res == sum_t'(sum_t'($past(in_a, 3)) * sum_t'($past(in_b, 3)))
                              + sum_t'($past(in_c, 2))));

endmodule

// File: tb/madd_pipe_tb.sv
module madd_pipe_tb;

   localparam int W    = 8;
   localparam int NCYC = 2048;
   localparam int WD   = 200000;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_vld = 1'b0;
   logic [W-1:0]     in_a = '0;
   logic [W-1:0]     in_b = '0;
   logic [2*W-1:0]   in_c = '0;
   logic             out_vld;
   logic [2*W:0]     out_res;

   always #4 clk = ~clk;

   madd_pipe #(.W(W)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (in_vld),
      .in_a    (in_a),
      .in_b    (in_b),
      .in_c    (in_c),
      .out_vld (out_vld),
      .out_res (out_res)
   );

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   bit             hv [NCYC];
   bit             hr [NCYC];
   logic [W-1:0]   ha [NCYC];
   logic [W-1:0]   hb [NCYC];
   logic [2*W-1:0] hc [NCYC];
   bit             ov [NCYC];

   function automatic logic [2*W:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [2*W-1:0] c);
      return (2*W+1)'(a) * (2*W+1)'(b) + (2*W+1)'(c);
   endfunction

   task automatic check_now(input int k);
      bit exp_v;
      logic [2*W:0] exp_r;
      ov[k] = out_vld;
      if (k < 3) return;
      exp_v = hv[k-3] && !hr[k-3] && !hr[k-2] && !hr[k-1];
      checks++;
      if (out_vld !== exp_v) begin
         failures++;
         if (hr[k-1] || hr[k-2] || hr[k-3])
            $display("FAIL R1 cycle %0d out_vld=%b expected %b", k, out_vld, exp_v);
         else if (!exp_v)
            $display("FAIL R5 cycle %0d out_vld=%b expected %b", k, out_vld, exp_v);
         else
            $display("FAIL R4 cycle %0d out_vld=%b expected %b", k, out_vld, exp_v);
      end
      if (exp_v) begin
         exp_r = ref_sum(ha[k-3], hb[k-3], hc[k-2]);
         checks++;
         if (out_res !== exp_r) begin
            failures++;
            if (ha[k-3] == '1 && hb[k-3] == '1)
               $display("FAIL R6 cycle %0d out_res=%0d expected %0d", k, out_res, exp_r);
            else
               $display("FAIL R2 cycle %0d out_res=%0d expected %0d", k, out_res, exp_r);
         end
      end
   endtask

   // c is the addend for the set driven in the previous step
   task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [2*W-1:0] c, input bit r);
      @(negedge clk);
      check_now(cyc);
      hv[cyc] = v;  hr[cyc] = r;
      ha[cyc] = a;  hb[cyc] = b;  hc[cyc] = c;
      in_vld = v;  in_a = a;  in_b = b;  in_c = c;  rst = r;
      cyc++;
   endtask

   function automatic logic [W-1:0] rnd_w();
      return W'($urandom);
   endfunction

   function automatic logic [2*W-1:0] rnd_c();
      return (2*W)'($urandom);
   endfunction

   initial begin
      int burst_s;
      int first_out;
      int run;
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < NCYC; i++) begin
         hv[i] = 0; hr[i] = 0; ov[i] = 0;
         ha[i] = '0; hb[i] = '0; hc[i] = '0;
      end

      // R1: reset holds, outputs must stay idle
      for (int i = 0; i < 5; i++) step(0, '0, '0, '0, 1);
      step(0, '0, '0, '0, 0);
      step(0, '0, '0, '0, 0);

      // R4 / R6: seven sets back to back, last one at full scale
      burst_s = cyc;
      for (int i = 0; i < 7; i++) begin
         if (i == 6) step(1, '1, '1, (2*W)'(i * 1000 + 7), 0);
         else        step(1, W'(i * 37 + 1), W'(i * 19 + 3), (2*W)'(i * 1000 + 7), 0);
      end
      step(0, '0, '0, '1, 0);    // addend for the full-scale set
      for (int i = 0; i < 6; i++) step(0, rnd_w(), rnd_w(), rnd_c(), 0);

      // R3: first result three edges after the first capture
      first_out = -1;
      for (int k = burst_s; k < burst_s + 12; k++)
         if (ov[k] && first_out < 0) first_out = k;
      checks++;
      if (first_out != burst_s + 3) begin
         failures++;
         $display("FAIL R3 first result at cycle %0d expected %0d", first_out, burst_s + 3);
      end
      // R4: 7 contiguous results, 3+(7-1) edges from first capture to last result
      run = 0;
      for (int k = burst_s + 3; k < burst_s + 12; k++) if (ov[k]) run++;
      checks++;
      if (run != 7 || !ov[burst_s + 9] || ov[burst_s + 10]) begin
         failures++;
         $display("FAIL R4 burst results=%0d last_at=%0d expected 7 ending at %0d",
                  run, burst_s + 9, burst_s + 9);
      end

      // R5: gaps of 1, 2 and 3 cycles between sets
      for (int g = 1; g <= 3; g++) begin
         step(1, rnd_w(), rnd_w(), rnd_c(), 0);
         step(1, rnd_w(), rnd_w(), rnd_c(), 0);
         for (int j = 0; j < g; j++) step(0, rnd_w(), rnd_w(), rnd_c(), 0);
      end

      // Random bursts: overlapping factor and addend capture
      for (int i = 0; i < 1200; i++)
         step(($urandom % 10) < 7, rnd_w(), rnd_w(), rnd_c(), 0);

      // R1: reset pulse with the pipe full, then resume
      for (int i = 0; i < 4; i++) step(1, rnd_w(), rnd_w(), rnd_c(), 0);
      step(1, rnd_w(), rnd_w(), rnd_c(), 1);
      for (int i = 0; i < 6; i++) step(1, rnd_w(), rnd_w(), rnd_c(), 0);

      // Drain
      for (int i = 0; i < 6; i++) step(0, rnd_w(), rnd_w(), rnd_c(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(WD * 8);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule